// File: doc/BRIEF.md
# Floating-Point Control and Status Word

This block keeps the 32-bit control and status word of a floating-point unit. The word holds two live fields: a 3-bit dynamic rounding mode and a 5-bit set of sticky exception flags. The remaining upper bits are reserved. They always read as zero, and writes to them are dropped. The integer side reaches the word through one CSR port. A 2-bit select on that port chooses the whole word, the rounding field alone or the flag field alone. Each access is either a plain read or a swap: the old value is returned, and the chosen field is then loaded from the low bits of the write data.

Floating-point operations use the block in two ways. When an operation completes, it reports its exception bits, and the block ORs them into the sticky flags. Hardware never clears those flags. When an operation issues, it presents the 3-bit rounding field from its instruction. The block resolves that field into the effective rounding mode, taking the dynamic field when the static field is 111. It raises an illegal-instruction indication when the result is not a defined mode.

Top module: `fpcsr_word`

## Requirements
- R1: After reset the rounding field and the flag field are zero, so every read view returns 0.
- R2: Select 2'b11 is the whole word. A read returns bits 7..5 = rounding mode, bits 4..0 = flags (bit 4 invalid, 3 divide-by-zero, 2 overflow, 1 underflow, 0 inexact), and bits 31..8 = 0. A swap loads the rounding mode from write data bits 7..5 and the flags from bits 4..0. Write data bits 31..8 have no effect on any later read.
- R3: Select 2'b10 is the rounding view. A read returns the mode in bits 2..0 with all other bits zero. A swap loads the mode from write data bits 2..0 and leaves the flags unchanged.
- R4: Select 2'b01 is the flag view. A read returns the flags in bits 4..0 with all other bits zero. A swap loads the flags from write data bits 4..0 and leaves the mode unchanged.
- R5: Read data is combinational and shows the value held before the access. A swapped value becomes visible from the next clock cycle.
- R6: With the request low, or with select 2'b00, read data is zero and the stored state does not change.
- R7: A completion pulse ORs the reported 5-bit exception bits into the flags. No hardware event clears a flag.
- R8: If a software write to the flags and a completion pulse fall in the same cycle, the new flags are the write value ORed with the reported bits.
- R9: A static rounding field from 000 to 100 (000 nearest-even, 001 toward zero, 010 down, 011 up, 100 nearest-max-magnitude) is the effective mode, and it is never illegal.
- R10: A static field of 111 uses the stored mode as the effective mode. It is illegal when the stored mode is 101, 110 or 111.
- R11: A static field of 101 or 110 is illegal.
- R12: The illegal indication is asserted only while an operation request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_req | input | 1 | CSR access present this cycle |
| csr_sel | input | 2 | View: 01 flags, 10 rounding, 11 whole word, 00 none |
| csr_swap | input | 1 | Access writes the selected field after returning it |
| csr_wdata | input | 32 | Write data for a swap |
| csr_rdata | output | 32 | Pre-access value of the selected view |
| fp_done | input | 1 | A floating-point operation completes |
| fp_exc | input | 5 | Exception bits of the completing operation |
| fp_req | input | 1 | A floating-point operation asks for a rounding mode |
| fp_rm_static | input | 3 | Rounding field of the issuing instruction |
| fp_rm_eff | output | 3 | Resolved rounding mode |
| fp_rm_illegal | output | 1 | Resolution failed; the instruction is illegal |

## Verification
A corrupted rounding field shows up on the CSR read data in the very next access. It shows up at once on the resolved mode and the illegal indication for any operation that uses dynamic rounding. A lost or wrongly cleared flag stays hidden until software reads the flags, so the bench reads the word often and after every pattern of completion pulses. It also mixes writes that collide with completions in the same cycle, so that a merge error appears in the following read.

// File: rtl/fpcsr_word.sv
module fpcsr_word #(
  parameter int XLEN   = 32,
  parameter int RM_W   = 3,
  parameter int FLAG_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_req,
  input  logic [1:0]      csr_sel,
  input  logic            csr_swap,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  input  logic            fp_done,
  input  logic [FLAG_W-1:0] fp_exc,
  input  logic            fp_req,
  input  logic [RM_W-1:0] fp_rm_static,
  output logic [RM_W-1:0] fp_rm_eff,
  output logic            fp_rm_illegal
);
  localparam logic [1:0] SEL_FLAGS = 2'b01;
  localparam logic [1:0] SEL_RM    = 2'b10;
  localparam logic [1:0] SEL_WORD  = 2'b11;
  localparam logic [RM_W-1:0] RM_DYN   = '1;
  localparam logic [RM_W-1:0] RM_LAST  = RM_W'(4);
  localparam int LIVE_W = RM_W + FLAG_W;

  logic [RM_W-1:0]   rm_q;
  logic [FLAG_W-1:0] flags_q;

  wire acc      = csr_req && (csr_sel != 2'b00);
  wire wr       = acc && csr_swap;
  wire wr_rm    = wr && (csr_sel == SEL_RM || csr_sel == SEL_WORD);
  wire wr_flags = wr && (csr_sel == SEL_FLAGS || csr_sel == SEL_WORD);

  wire [RM_W-1:0]   rm_new    = (csr_sel == SEL_WORD) ? csr_wdata[LIVE_W-1:FLAG_W]
                                                      : csr_wdata[RM_W-1:0];
  wire [FLAG_W-1:0] exc_in    = fp_done ? fp_exc : '0;
  wire [FLAG_W-1:0] flags_nxt = (wr_flags ? csr_wdata[FLAG_W-1:0] : flags_q) | exc_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rm_q    <= '0;
      flags_q <= '0;
    end else begin
      if (wr_rm) rm_q <= rm_new;
      flags_q <= flags_nxt;
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (acc) begin
      case (csr_sel)
        SEL_FLAGS: csr_rdata[FLAG_W-1:0] = flags_q;
        SEL_RM:    csr_rdata[RM_W-1:0]   = rm_q;
        default:   csr_rdata[LIVE_W-1:0] = {rm_q, flags_q};
      endcase
    end
  end

  assign fp_rm_eff     = (fp_rm_static == RM_DYN) ? rm_q : fp_rm_static;
  assign fp_rm_illegal = fp_req && (fp_rm_eff > RM_LAST);

  assert_flags_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flags |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_merge_or_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flags && fp_done) |=> (flags_q == ($past(csr_wdata[FLAG_W-1:0]) | $past(fp_exc))));

  assert_rm_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_swap && csr_sel == SEL_RM) |=> (rm_q == $past(csr_wdata[RM_W-1:0])));

  assert_rm_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rm |=> $stable(rm_q));

  assert_static_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_rm_static <= RM_LAST) |-> (fp_rm_eff == fp_rm_static && !fp_rm_illegal));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !fp_req |-> !fp_rm_illegal);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[XLEN-1:LIVE_W] == '0);
endmodule

// File: tb/fpcsr_word_tb.sv
module fpcsr_word_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND = 600;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        csr_req = 0;
  logic [1:0]  csr_sel = 0;
  logic        csr_swap = 0;
  logic [31:0] csr_wdata = 0;
  logic [31:0] csr_rdata;
  logic        fp_done = 0;
  logic [4:0]  fp_exc = 0;
  logic        fp_req = 0;
  logic [2:0]  fp_rm_static = 0;
  logic [2:0]  fp_rm_eff;
  logic        fp_rm_illegal;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [2:0] m_rm = 0;
  logic [4:0] m_fl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpcsr_word dut_i (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_sel(csr_sel),
    .csr_swap(csr_swap), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .fp_done(fp_done), .fp_exc(fp_exc), .fp_req(fp_req),
    .fp_rm_static(fp_rm_static), .fp_rm_eff(fp_rm_eff),
    .fp_rm_illegal(fp_rm_illegal)
  );

  function automatic logic [31:0] exp_rdata(logic req, logic [1:0] sel);
    if (!req) return 32'h0;
    case (sel)
      2'b01: return {27'h0, m_fl};
      2'b10: return {29'h0, m_rm};
      2'b11: return {24'h0, m_rm, m_fl};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [2:0] exp_eff(logic [2:0] st);
    return (st == 3'b111) ? m_rm : st;
  endfunction

  function automatic logic exp_ill(logic req, logic [2:0] st);
    return req && (exp_eff(st) > 3'd4);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(logic req, logic [1:0] sel, logic swp, logic [31:0] wd,
                      logic dn, logic [4:0] ex, logic oreq, logic [2:0] st);
    string rtag;
    @(negedge clk);
    csr_req = req; csr_sel = sel; csr_swap = swp; csr_wdata = wd;
    fp_done = dn; fp_exc = ex; fp_req = oreq; fp_rm_static = st;
    #1;
    rtag = (!req || sel == 2'b00) ? "R6 read idle" :
           (sel == 2'b01) ? "R4 flag view" :
           (sel == 2'b10) ? "R3 rm view" : "R2 word view";
    chk({rtag, " (R5 pre-access value)"}, csr_rdata, exp_rdata(req, sel));
    chk((st == 3'b111) ? "R10 dynamic eff" : "R9 static eff",
        {29'h0, fp_rm_eff}, {29'h0, exp_eff(st)});
    chk((st == 3'b101 || st == 3'b110) ? "R11 reserved static" :
        (!oreq) ? "R12 illegal gated" : "R10 illegal",
        {31'h0, fp_rm_illegal}, {31'h0, exp_ill(oreq, st)});
    @(posedge clk);
    if (req && swp && (sel == 2'b10)) m_rm = wd[2:0];
    if (req && swp && (sel == 2'b11)) m_rm = wd[7:5];
    if (req && swp && (sel == 2'b01 || sel == 2'b11)) m_fl = wd[4:0];
    if (dn) m_fl = m_fl | ex;
  endtask

  task automatic idle();
    step(0, 2'b00, 0, 32'h0, 0, 5'h0, 0, 3'b000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset word", csr_rdata, 32'h0);
    rst_n = 1;
    step(1, 2'b11, 0, 32'h0, 0, 5'h0, 1, 3'b111);          // R1 word zero, dyn=RNE
    step(1, 2'b11, 1, 32'hFFFF_FF00 | 32'hAB, 0, 5'h0, 0, 3'b000); // R2 reserved ignored
    step(1, 2'b11, 0, 32'h0, 0, 5'h0, 0, 3'b000);          // R2 reads 0xAB only
    step(1, 2'b10, 1, 32'hFFFF_FFF9, 0, 5'h0, 0, 3'b000);  // R3 write 001, flags kept
    step(1, 2'b01, 0, 32'h0, 0, 5'h0, 0, 3'b000);          // R3 flags unchanged
    step(1, 2'b01, 1, 32'hFFFF_FFE0, 0, 5'h0, 0, 3'b000);  // R4 clear flags
    step(1, 2'b10, 0, 32'h0, 0, 5'h0, 0, 3'b000);          // R4 rm unchanged
    step(0, 2'b11, 1, 32'hFF, 0, 5'h0, 0, 3'b000);         // R6 no req
    step(1, 2'b00, 1, 32'hFF, 0, 5'h0, 0, 3'b000);         // R6 sel 00
    step(1, 2'b11, 0, 32'h0, 1, 5'h04, 0, 3'b000);         // R7 OF
    step(0, 2'b00, 0, 32'h0, 1, 5'h01, 0, 3'b000);         // R7 NX
    step(0, 2'b00, 0, 32'h0, 0, 5'h1F, 0, 3'b000);         // R7 no done, no effect
    step(1, 2'b01, 1, 32'h10, 1, 5'h02, 0, 3'b000);        // R8 merge -> 0x12
    step(1, 2'b01, 0, 32'h0, 0, 5'h0, 0, 3'b000);
    step(1, 2'b10, 1, 32'h5, 0, 5'h0, 1, 3'b111);          // R10 set dyn 101
    step(0, 2'b00, 0, 32'h0, 0, 5'h0, 1, 3'b111);          // R10 illegal
    step(0, 2'b00, 0, 32'h0, 0, 5'h0, 0, 3'b111);          // R12 gated
    step(0, 2'b00, 0, 32'h0, 0, 5'h0, 1, 3'b101);          // R11
    step(0, 2'b00, 0, 32'h0, 0, 5'h0, 1, 3'b110);          // R11
    for (int s = 0; s < 5; s++) step(0, 2'b00, 0, 32'h0, 0, 5'h0, 1, 3'(s)); // R9
    step(1, 2'b10, 1, 32'h7, 0, 5'h0, 0, 3'b000);
    step(0, 2'b00, 0, 32'h0, 0, 5'h0, 1, 3'b111);          // R10 dyn 111 illegal
    step(1, 2'b10, 1, 32'h4, 0, 5'h0, 0, 3'b000);
    step(0, 2'b00, 0, 32'h0, 0, 5'h0, 1, 3'b111);          // R10 dyn RMM legal
    idle();
    for (int i = 0; i < N_RAND; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[2:1], r[3], $urandom, r[4], r[9:5], r[10], r[13:11]);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule